// File: doc/BRIEF.md
# Address Breakpoint Trigger Unit

This unit watches the address bus of a processor core. On each clock edge where the core marks its address as valid, the address is checked against a 16-bit compare value that software programs one byte at a time. If the values match and triggering is armed, the unit raises an active-high breakpoint line and sets a sticky hit flag. Debug logic or an external probe can then act on that line.

The line has two behaviours, chosen by a mode bit in the control register. In pulse mode it goes high for a fixed window of eight clocks, and each new match starts the window again. In level mode it stays high until software writes a one to the hit flag position. The compare bytes and the control register can be read back through a combinational read port.

Top module: `addr_break_unit`

## Requirements
- R1: After a synchronous active-high reset, break_out is 0 and all three registers read 0 (select 0 = compare low byte, 1 = compare high byte, 2 = control). Select 3 reads 0.
- R2: A write to select 0 sets compare bits 7:0 and a write to select 1 sets bits 15:8. Both read back as written. A match needs all 16 address bits to equal the compare value.
- R3: When the enable bit (control bit 0) is 0, a matching address has no effect: break_out stays low and the hit flag stays clear.
- R4: With the mode bit (control bit 1) at 1, a match sampled at a clock edge drives break_out high for exactly 8 cycles, starting right after that edge, and then low.
- R5: In pulse mode, a new match while a pulse is running restarts the full 8-cycle window from that edge.
- R6: With the mode bit at 0, a match drives break_out high from the next cycle onward. It stays high until a write to control with bit 2 set.
- R7: The hit flag (control bit 2) is set by every enabled match in both modes. Writing 1 to bit 2 clears it, and writing 0 there leaves it unchanged. In pulse mode the flag has no effect on break_out.
- R8: Clearing the enable bit while break_out is held in level mode does not lower break_out.
- R9: If a match and a flag-clearing write fall in the same cycle, the match wins: the flag stays set and a held level stays high.
- R10: An address presented with addr_valid low never triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_valid | input | 1 | Address qualifier for this cycle |
| addr | input | 16 | Processor address bus |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data, combinational |
| break_out | output | 1 | Breakpoint line, active high |

## Verification
The assertions assume that the enable and mode values in effect when a match is sampled are the ones held before that edge, and that the compare value does not change on the same edge as a match. They also assume that reset lasts at least one full clock. The stimulus keeps every register write in a cycle of its own, apart from the deliberate flag-clear-with-match case. It also drives matching addresses only after the compare bytes and control bits have settled.

// File: rtl/abu_pkg.sv
package abu_pkg;
  typedef enum logic [1:0] {
    SEL_CMP_LO = 2'd0,
    SEL_CMP_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_HIT_BIT  = 2;
endpackage

// File: rtl/abu_regs.sv
module abu_regs
  import abu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CMP_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit_evt,
  output logic [CMP_W-1:0]  cmp_addr,
  output logic              en_q,
  output logic              mode_q,
  output logic              hit_flag,
  output logic              clr_req
);
  logic [DATA_W-1:0] cmp_lo_q, cmp_hi_q;
  logic              wr_ctrl;

  assign wr_ctrl  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign clr_req  = wr_ctrl && wr_data[CTRL_HIT_BIT];
  assign cmp_addr = {cmp_hi_q, cmp_lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
      en_q     <= 1'b0;
      mode_q   <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_CMP_LO: cmp_lo_q <= wr_data;
        SEL_CMP_HI: cmp_hi_q <= wr_data;
        SEL_CTRL: begin
          en_q   <= wr_data[CTRL_EN_BIT];
          mode_q <= wr_data[CTRL_MODE_BIT];
        end
        default: ;
      endcase
    end
  end

  // sticky flag: a match outranks a clearing write
  always_ff @(posedge clk) begin
    if (rst)          hit_flag <= 1'b0;
    else if (hit_evt) hit_flag <= 1'b1;
    else if (clr_req) hit_flag <= 1'b0;
  end
endmodule

// File: rtl/abu_match.sv
module abu_match #(
  parameter int ADDR_W = 16
) (
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              en_q,
  output logic              hit_evt
);
  function automatic logic addr_equal(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  assign hit_evt = addr_valid && en_q && addr_equal(addr, cmp_addr);
endmodule

// File: rtl/abu_out.sv
module abu_out #(
  parameter int PULSE_LEN = 8,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_evt,
  input  logic             mode_q,
  input  logic             clr_req,
  output logic             level_q,
  output logic [CNT_W-1:0] pulse_cnt,
  output logic             break_out
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                 input logic reload);
    if (reload)      return CNT_W'(PULSE_LEN);
    else if (c != 0) return c - 1'b1;
    else             return c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) pulse_cnt <= '0;
    else     pulse_cnt <= next_count(pulse_cnt, hit_evt && mode_q);
  end

  always_ff @(posedge clk) begin
    if (rst)                    level_q <= 1'b0;
    else if (hit_evt && !mode_q) level_q <= 1'b1;
    else if (clr_req && !hit_evt) level_q <= 1'b0;
  end

  assign break_out = level_q || (pulse_cnt != '0);
endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
  import abu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PULSE_LEN = 8,
  localparam int ADDR_W   = 2 * DATA_W,
  localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              break_out
);
  logic [ADDR_W-1:0] cmp_addr;
  logic              en_q, mode_q, hit_flag, clr_req, hit_evt, level_q;
  logic [CNT_W-1:0]  pulse_cnt;

  abu_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hit_evt(hit_evt), .cmp_addr(cmp_addr), .en_q(en_q), .mode_q(mode_q),
    .hit_flag(hit_flag), .clr_req(clr_req)
  );

  abu_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_valid(addr_valid), .addr(addr), .cmp_addr(cmp_addr),
    .en_q(en_q), .hit_evt(hit_evt)
  );

  abu_out #(.PULSE_LEN(PULSE_LEN)) u_out (
    .clk(clk), .rst(rst), .hit_evt(hit_evt), .mode_q(mode_q),
    .clr_req(clr_req), .level_q(level_q), .pulse_cnt(pulse_cnt),
    .break_out(break_out)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_CMP_LO: rd_data = cmp_addr[DATA_W-1:0];
      SEL_CMP_HI: rd_data = cmp_addr[ADDR_W-1:DATA_W];
      SEL_CTRL:   rd_data = {{(DATA_W-3){1'b0}}, hit_flag, mode_q, en_q};
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/abu_checker.sv
module abu_checker #(
  parameter int PULSE_LEN = 8,
  localparam int SW = $clog2(PULSE_LEN + 2)
) (
  input logic clk,
  input logic rst,
  input logic hit_evt,
  input logic mode_q,
  input logic clr_req,
  input logic level_q,
  input logic hit_flag,
  input logic break_out
);
  logic [SW-1:0] since_p;

  always_ff @(posedge clk) begin
    if (rst)                        since_p <= SW'(PULSE_LEN + 1);
    else if (hit_evt && mode_q)     since_p <= SW'(1);
    else if (since_p <= SW'(PULSE_LEN)) since_p <= since_p + 1'b1;
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> (!break_out && !hit_flag));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst) hit_evt |=> hit_flag);
  // R6
  level_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_evt && !mode_q) |=> break_out);
  // R4
  pulse_window_chk: assert property (@(posedge clk) disable iff (rst)
    (since_p >= SW'(1) && since_p <= SW'(PULSE_LEN)) |-> break_out);
  // R4
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (since_p == SW'(PULSE_LEN + 1) && !level_q) |-> !break_out);
  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !hit_evt) |=> !hit_flag);
  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (level_q && !clr_req) |=> break_out);
endmodule

bind addr_break_unit abu_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .hit_evt(hit_evt), .mode_q(mode_q), .clr_req(clr_req),
  .level_q(level_q), .hit_flag(hit_flag), .break_out(break_out)
);

// File: tb/addr_break_unit_test.sv
module addr_break_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_valid = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic        break_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_break_unit uut (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr(addr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .break_out(break_out)
  );

  typedef struct {
    logic       out;
    logic [7:0] rd;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // reference state, kept from the requirements
  logic [15:0] m_cmp = '0;
  logic m_en = 0, m_mode = 0, m_flag = 0, m_lvl = 0;
  int   m_left = 0;

  task automatic step(input logic v, input logic [15:0] a, input logic w,
                      input logic [1:0] s, input logic [7:0] d,
                      input logic [1:0] rs, input string tag);
    logic hit;
    exp_t e;
    @(negedge clk);
    addr_valid = v; addr = a; wr_en = w; wr_sel = s; wr_data = d; rd_sel = rs;
    hit = v && m_en && (a == m_cmp);
    if (hit && m_mode) m_left = 8;
    else if (m_left > 0) m_left--;
    if (hit && !m_mode) m_lvl = 1;
    else if (w && s == 2 && d[2]) m_lvl = 0;
    if (hit) m_flag = 1;
    else if (w && s == 2 && d[2]) m_flag = 0;
    if (w) begin
      if (s == 0) m_cmp[7:0] = d;
      if (s == 1) m_cmp[15:8] = d;
      if (s == 2) begin m_en = d[0]; m_mode = d[1]; end
    end
    e.out = m_lvl || (m_left > 0);
    case (rs)
      2'd0: e.rd = m_cmp[7:0];
      2'd1: e.rd = m_cmp[15:8];
      2'd2: e.rd = {5'b0, m_flag, m_mode, m_en};
      default: e.rd = 8'h00;
    endcase
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 16'h0, 0, 0, 0, 2'd2, tag);
  endtask

  task automatic wreg(input logic [1:0] s, input logic [7:0] d, input string tag);
    step(0, 16'h0, 1, s, d, s, tag);
  endtask

  task automatic probe(input logic [15:0] a, input logic v, input string tag);
    step(v, a, 0, 0, 0, 2'd2, tag);
  endtask

  // monitor: compares just after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (break_out !== e.out) begin
        errors++;
        $display("FAIL %s break_out actual %0b expected %0b", e.tag, break_out, e.out);
      end
      checks++;
      if (rd_data !== e.rd) begin
        errors++;
        $display("FAIL %s rd_data actual %02h expected %02h", e.tag, rd_data, e.rd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state of every register
    step(0, 0, 0, 0, 0, 2'd0, "R1");
    step(0, 0, 0, 0, 0, 2'd1, "R1");
    step(0, 0, 0, 0, 0, 2'd2, "R1");
    step(0, 0, 0, 0, 0, 2'd3, "R1");
    // R2 program compare bytes
    wreg(2'd0, 8'h34, "R2");
    wreg(2'd1, 8'h12, "R2");
    // R3 disabled: matching address ignored
    probe(16'h1234, 1, "R3");
    idle(2, "R3");
    wreg(2'd2, 8'h03, "R4");
    // R10 valid low
    probe(16'h1234, 0, "R10");
    // R2 partial matches
    probe(16'h1235, 1, "R2");
    probe(16'h0234, 1, "R2");
    idle(1, "R2");
    // R4 single pulse
    probe(16'h1234, 1, "R4");
    idle(11, "R4");
    // R5 restart
    probe(16'h1234, 1, "R5");
    idle(3, "R5");
    probe(16'h1234, 1, "R5");
    idle(11, "R5");
    // R7 write zero keeps flag, write one clears
    wreg(2'd2, 8'h03, "R7");
    idle(1, "R7");
    wreg(2'd2, 8'h07, "R7");
    idle(1, "R7");
    // R6 level mode
    wreg(2'd2, 8'h01, "R6");
    probe(16'h1234, 1, "R6");
    idle(5, "R6");
    // R8 disable does not drop level
    wreg(2'd2, 8'h00, "R8");
    idle(3, "R8");
    probe(16'h1234, 1, "R8");
    wreg(2'd2, 8'h04, "R6");
    idle(2, "R6");
    // R9 match and clear in the same cycle
    wreg(2'd2, 8'h01, "R9");
    probe(16'h1234, 1, "R9");
    step(1, 16'h1234, 1, 2'd2, 8'h05, 2'd2, "R9");
    idle(2, "R9");
    wreg(2'd2, 8'h05, "R9");
    idle(2, "R9");
    // R3 disabled in pulse mode
    wreg(2'd2, 8'h02, "R3");
    probe(16'h1234, 1, "R3");
    idle(3, "R3");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule